// File: doc/BRIEF.md
# Two-wire pointer-register target interface

This block is the target side of a two-wire serial bus (SCL clock, open-drain SDA data) in front of a small register file of 16-bit registers. Both bus lines are synchronised into the system clock domain. Start and stop conditions are detected from the synchronised lines. The block answers to a 7-bit address made of a fixed upper part and a 3-bit strap input, so up to eight copies can share one bus.

A transaction with the direction bit low always carries a pointer byte first. That byte selects one register and stays in effect across later transactions. Any byte pairs that follow are written to the selected register, high byte first. A transaction with the direction bit high returns the selected register, high byte first. If the controller keeps acknowledging, the read repeats the same register. The register file sits outside the block and connects through an address output, a write strobe with write data, and a read-data input that must reflect the current address.

Top module: `twi_ptr_target`

## Requirements
- R1: A start condition (SDA falling while SCL is high) aborts whatever is in progress, including a partly shifted byte, and begins a new address phase. A stop condition (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: When the seven address bits, taken MSB first, equal {ADDR_HI, strap_i}, the block pulls SDA low (sda_pd_o = 1) for the ninth clock. The eighth bit is the direction (1 = read).
- R3: On a non-matching address the block gives no acknowledge and never pulls SDA low until the next start.
- R4: The first byte after a matching write address is loaded into the pointer, which appears on reg_addr_o, and is acknowledged.
- R5: A write that ends (by stop or repeated start) right after the pointer byte only changes the pointer and produces no write strobe.
- R6: Each pair of data bytes after the pointer gives exactly one single-cycle reg_we_o pulse. The pulse carries {first byte, second byte} to the register at the pointer and is issued when the second byte is acknowledged. Further pairs rewrite the same register.
- R7: A write that ends after an odd data byte discards that byte, so no strobe is issued for it.
- R8: A read returns the selected register's bits 15:8 and then bits 7:0, each byte MSB first.
- R9: The pointer keeps its value across any number of reads, including reads reached by repeated start, until a write reloads it.
- R10: In a read, the block releases SDA for the ninth clock and samples it. A low level (ACK) after the low byte restarts at the high byte of the same register. A high level (NACK) ends the transfer with SDA released.
- R11: sda_pd_o changes only while the synchronised SCL is low.
- R12: After reset sda_pd_o = 0, reg_we_o = 0 and reg_addr_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Low address bits from board straps |
| sda_pd_o | output | 1 | Pull-down enable for SDA (1 = drive low) |
| reg_addr_o | output | 8 | Current pointer, register address |
| reg_wdata_o | output | 16 | Write data for the register file |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 16 | Contents of the register at reg_addr_o |

## Verification
The states hardest to reach are the ones where the controller cuts a transaction short or stretches it. These are a write stopped after one data byte, a start arriving in the middle of a pointer byte, and a read acknowledged past its low byte so that it wraps. The bench's controller model is built from bit-level tasks, so it can issue a start or stop after any number of bits and acknowledge or refuse any read byte. Expected register contents and the queue of expected write strobes are kept separately from the design and compared on every clock.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_RD
  } twi_st_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_i;
          sda_pipe[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_target_fsm.sv
module twi_target_fsm
  import twi_pkg::*;
#(
  parameter int                 STRAP_W = 3,
  parameter logic [6-STRAP_W:0] ADDR_HI = 4'b1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [WORD_W-1:0]  rdata,
  output logic               pd,
  output logic [BYTE_W-1:0]  ptr,
  output logic [WORD_W-1:0]  wdata,
  output logic               we,
  output twi_st_e            st
);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] C_ACK  = CNT_W'(BYTE_W + 1);
  localparam logic [CNT_W-1:0] C_MACK = CNT_W'(BYTE_W + 2);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sr;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] lo_q;
  logic              rw;
  logic              hi_ok;
  logic              lo_next;
  logic              mack;
  logic [6:0]        dev_addr;

  assign dev_addr = {ADDR_HI, strap};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  cnt <= '0;    sr <= '0;    tx <= '0;
      hi_q <= '0;     lo_q <= '0;   pd <= 1'b0;  ptr <= '0;
      rw <= 1'b0;     hi_ok <= 1'b0; lo_next <= 1'b0; mack <= 1'b0;
      we <= 1'b0;     wdata <= '0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; pd <= 1'b0; hi_ok <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; cnt <= '0; pd <= 1'b0; hi_ok <= 1'b0;
      end else if (scl_rise) begin
        if (st != ST_IDLE && cnt < C_LAST) begin
          sr  <= {sr[BYTE_W-2:0], sda_s};
          cnt <= cnt + 1'b1;
        end else if (st == ST_RD && cnt == C_ACK) begin
          mack <= ~sda_s;
          cnt  <= C_MACK;
        end
      end else if (scl_fall) begin
        case (st)
          ST_ADDR: begin
            if (cnt == C_LAST) begin
              if (sr[BYTE_W-1:1] == dev_addr) begin
                pd <= 1'b1; rw <= sr[0]; cnt <= C_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (cnt == C_ACK) begin
              cnt <= '0;
              if (rw) begin
                st <= ST_RD; tx <= rdata[WORD_W-1:BYTE_W];
                lo_q <= rdata[BYTE_W-1:0]; lo_next <= 1'b1;
                pd <= ~rdata[WORD_W-1];
              end else begin
                st <= ST_PTR; pd <= 1'b0;
              end
            end
          end
          ST_PTR: begin
            if (cnt == C_LAST) begin
              ptr <= sr; pd <= 1'b1; cnt <= C_ACK;
            end else if (cnt == C_ACK) begin
              pd <= 1'b0; cnt <= '0; st <= ST_WR; hi_ok <= 1'b0;
            end
          end
          ST_WR: begin
            if (cnt == C_LAST) begin
              pd <= 1'b1; cnt <= C_ACK;
              if (!hi_ok) begin
                hi_q <= sr; hi_ok <= 1'b1;
              end else begin
                we <= 1'b1; wdata <= {hi_q, sr}; hi_ok <= 1'b0;
              end
            end else if (cnt == C_ACK) begin
              pd <= 1'b0; cnt <= '0;
            end
          end
          ST_RD: begin
            if (cnt != '0 && cnt < C_LAST) begin
              tx <= {tx[BYTE_W-2:0], 1'b0};
              pd <= ~tx[BYTE_W-2];
            end else if (cnt == C_LAST) begin
              pd <= 1'b0; cnt <= C_ACK;
            end else if (cnt == C_MACK) begin
              cnt <= '0;
              if (!mack) begin
                st <= ST_IDLE;
              end else if (lo_next) begin
                tx <= lo_q; pd <= ~lo_q[BYTE_W-1]; lo_next <= 1'b0;
              end else begin
                tx <= rdata[WORD_W-1:BYTE_W]; lo_q <= rdata[BYTE_W-1:0];
                pd <= ~rdata[WORD_W-1]; lo_next <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_ptr_target.sv
module twi_ptr_target
  import twi_pkg::*;
#(
  parameter int                 STRAP_W     = 3,
  parameter logic [6-STRAP_W:0] ADDR_HI     = 4'b1000,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_pd_o,
  output logic [BYTE_W-1:0]  reg_addr_o,
  output logic [WORD_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  input  logic [WORD_W-1:0]  reg_rdata_i
);
  logic    scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  twi_st_e st;

  twi_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_target_fsm #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) fsm_i (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap_i), .rdata(reg_rdata_i), .pd(sda_pd_o), .ptr(reg_addr_o),
    .wdata(reg_wdata_o), .we(reg_we_o), .st(st)
  );
endmodule

// File: rtl/twi_ptr_target_chk.sv
module twi_ptr_target_chk
  import twi_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    scl_s,
  input logic    sda_pd_o,
  input logic    reg_we_o,
  input twi_st_e st
);
  // R11: pull-down toggles only after SCL was seen low
  a_r11_pd_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pd_o) |-> !$past(scl_s));

  // R6: write strobe lasts a single cycle
  a_r6_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |=> !reg_we_o);

  // R6: strobe coincides with acknowledging the second byte
  a_r6_we_with_ack: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |-> sda_pd_o);

  // R3: idle (including after a mismatch) never drives the line
  a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_pd_o);
endmodule

bind twi_ptr_target twi_ptr_target_chk chk_i (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pd_o(sda_pd_o),
  .reg_we_o(reg_we_o), .st(st)
);

// File: tb/twi_ptr_target_tb.sv
module twi_ptr_target_tb_top;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  strap = 3'd5;
  logic        sda_pd;
  logic [7:0]  raddr;
  logic [15:0] wdata;
  logic        we;
  logic [15:0] rdata;
  wire         sda_line = sda_m & ~sda_pd;

  logic [15:0] rf     [256];
  logic [15:0] exp_rf [256];
  logic [23:0] exp_wq [$];
  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit watch_pd = 1'b0;
  bit pd_seen = 1'b0;
  bit prev_pd = 1'b0;
  int r11_bad = 0;

  always #5 clk = ~clk;

  twi_ptr_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .sda_pd_o(sda_pd), .reg_addr_o(raddr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_rdata_i(rdata)
  );

  assign rdata = rf[raddr];
  always @(posedge clk) if (we) rf[raddr] <= wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // per-clock monitor: write strobes against the expected queue, line timing
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
    if (!rst) begin
      if (we) begin
        if (exp_wq.size() == 0) chk("R6 R7 unexpected strobe", {raddr, wdata}, 24'hxxxxxx);
        else chk("R6 strobe addr/data", {8'h00, raddr, wdata}, {8'h00, exp_wq.pop_front()});
      end
      if (sda_pd !== prev_pd && scl_m) r11_bad++;
      if (watch_pd && sda_pd) pd_seen = 1'b1;
    end
    prev_pd = sda_pd;
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(ack_n);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      bit_in(b);
      v[i] = b;
    end
    bit_out(~give_ack);
  endtask

  task automatic expect_write(input logic [7:0] a, input logic [15:0] d);
    exp_wq.push_back({a, d});
    exp_rf[a] = d;
  endtask

  initial begin
    logic       a;
    logic [7:0] h, l, h2;
    logic [6:0] dev;
    for (int i = 0; i < 256; i++) begin
      rf[i]     = 16'(i * 16'h0101) ^ 16'hA53C;
      exp_rf[i] = 16'(i * 16'h0101) ^ 16'hA53C;
    end
    dev = 7'h45;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R12 pd after reset", 32'(sda_pd), 32'd0);
    chk("R12 we after reset", 32'(we), 32'd0);
    chk("R12 pointer after reset", 32'(raddr), 32'd0);

    // full 16-bit write
    do_start();
    wbyte({dev, 1'b0}, a); chk("R2 ack on write address", 32'(a), 32'd0);
    wbyte(8'h12, a);       chk("R4 ack pointer byte", 32'(a), 32'd0);
    chk("R4 pointer on reg_addr_o", 32'(raddr), 32'h12);
    expect_write(8'h12, 16'hBEEF);
    wbyte(8'hBE, a);       chk("R6 ack high byte", 32'(a), 32'd0);
    wbyte(8'hEF, a);       chk("R6 ack low byte", 32'(a), 32'd0);
    do_stop();
    chk("R6 all strobes seen", 32'(exp_wq.size()), 32'd0);
    chk("R1 released after stop", 32'(sda_pd), 32'd0);

    // pointer-only write, then read
    do_start();
    wbyte({dev, 1'b0}, a); wbyte(8'h30, a);
    do_stop();
    chk("R5 pointer-only update", 32'(raddr), 32'h30);
    do_start();
    wbyte({dev, 1'b1}, a); chk("R2 ack on read address", 32'(a), 32'd0);
    rbyte(1'b1, h); rbyte(1'b0, l);
    chk("R8 read high byte first", 32'(h), 32'(exp_rf[8'h30][15:8]));
    chk("R8 read low byte second", 32'(l), 32'(exp_rf[8'h30][7:0]));
    chk("R10 released after NACK", 32'(sda_pd), 32'd0);
    do_stop();

    // pointer write then repeated-start read with wrap
    do_start();
    wbyte({dev, 1'b0}, a); wbyte(8'h12, a);
    do_start();
    wbyte({dev, 1'b1}, a);
    rbyte(1'b1, h); rbyte(1'b1, l); rbyte(1'b0, h2);
    do_stop();
    chk("R9 repeated-start read", {16'h0, h, l}, 32'hBEEF);
    chk("R10 ACK after low byte wraps to high", 32'(h2), 32'hBE);

    // read again without pointer write
    do_start();
    wbyte({dev, 1'b1}, a); rbyte(1'b1, h); rbyte(1'b0, l);
    do_stop();
    chk("R9 pointer kept across reads", {16'h0, h, l}, 32'hBEEF);

    // non-matching address
    watch_pd = 1'b1; pd_seen = 1'b0;
    do_start();
    wbyte({7'h46, 1'b0}, a); chk("R3 no ack on mismatch", 32'(a), 32'd1);
    wbyte(8'h00, a);         chk("R3 no ack on later byte", 32'(a), 32'd1);
    do_stop();
    watch_pd = 1'b0;
    chk("R3 line never pulled", 32'(pd_seen), 32'd0);
    chk("R3 pointer untouched", 32'(raddr), 32'h12);

    // write truncated after one data byte
    do_start();
    wbyte({dev, 1'b0}, a); wbyte(8'h40, a); wbyte(8'h11, a);
    do_stop();
    do_start();
    wbyte({dev, 1'b1}, a); rbyte(1'b1, h); rbyte(1'b0, l);
    do_stop();
    chk("R7 odd byte discarded", {16'h0, h, l}, 32'(exp_rf[8'h40]));

    // two pairs to the same register
    do_start();
    wbyte({dev, 1'b0}, a); wbyte(8'h50, a);
    expect_write(8'h50, 16'h1234); expect_write(8'h50, 16'h5678);
    wbyte(8'h12, a); wbyte(8'h34, a); wbyte(8'h56, a); wbyte(8'h78, a);
    do_stop();
    chk("R6 second pair strobed", 32'(exp_wq.size()), 32'd0);

    // start in the middle of a pointer byte aborts it
    do_start();
    wbyte({dev, 1'b0}, a);
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    do_start();
    wbyte({dev, 1'b1}, a); rbyte(1'b1, h); rbyte(1'b0, l);
    do_stop();
    chk("R1 partial pointer abandoned", 32'(raddr), 32'h50);
    chk("R1 read after aborted byte", {16'h0, h, l}, 32'h5678);

    // other strap value
    strap = 3'd0;
    do_start();
    wbyte({7'h40, 1'b1}, a); chk("R2 ack with new strap", 32'(a), 32'd0);
    rbyte(1'b1, h); rbyte(1'b0, l);
    do_stop();
    chk("R2 read with new strap", {16'h0, h, l}, 32'h5678);

    chk("R11 pd changed only with SCL low", 32'(r11_bad), 32'd0);
    finish_run();
  end
endmodule